// File: doc/BRIEF.md
# Small-Page Flash Command Sequencer

This block generates the command-latch and address-latch bus cycles that start every operation on a small-page NAND flash device, where a page holds at most 512 main bytes. A request carries an opcode, an optional column address and an optional row (page) address, each address flagged valid or absent. The sequencer drives one strobe per byte. The chip-enable line stays low for the whole latch sequence and is released at its end. The block then finishes in one of three ways: at once, after a fixed chip delay, or after a ready wait carried out by a separate waiter block through a request/done handshake.

Small-page devices address the main area in two halves plus a spare area, and a program-setup request must be preceded by the matching pointer command. The sequencer picks this command from the column value and rebases the column into the selected region, so a caller can pass a flat column. On a 16-bit data bus the column is given in words, except for opcodes whose address bytes are always byte-wide. Reset is handled separately on systems without a ready/busy line: after the chip delay a status command is issued and the completion is handed to status polling with its own time limit.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is low from the following cycle until one cycle after `done`, which is a single-cycle pulse at the end of each request.
- R2: Each byte is one strobe with `nand_we_n` low for WE_LOW cycles and then high for WE_HIGH cycles. Command bytes have `nand_cle`=1 and `nand_ale`=0. Address bytes have `nand_ale`=1 and `nand_cle`=0. The byte sits on `nand_dq[7:0]` with the upper lines zero, and `nand_ce_n` is low during every strobe.
- R3: For opcode 0x80 (program setup) with a column at or above 512, the command 0x50 is issued before 0x80 and 512 is subtracted from the column. Other opcodes get no pointer command.
- R4: For opcode 0x80, a column below 256 is preceded by 0x00 and sent unchanged. A column from 256 to 511 is preceded by 0x01 and has 256 subtracted.
- R5: With `cfg_bus16`=1 the column is shifted right by one after rebasing. Opcodes 0x90, 0xEC, 0xEE and 0xEF are exempt from this shift.
- R6: The column is sent as one address byte (its low 8 bits). The row follows as bits [7:0] and then [15:8], and as bits [23:16] too when `cfg_row3`=1.
- R7: A column or row whose valid flag is low produces no address byte for that part.
- R8: Opcodes 0x10, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF finish right after their last latch byte, with no delay and no wait request.
- R9: Opcode 0xFF with `cfg_rb_present`=0 sends 0xFF, idles for the chip delay, sends command 0x70, and then raises `wait_req` with `wait_poll`=1 and `wait_tmo_ms`=250. With `cfg_rb_present`=1 it takes the ready wait of R11.
- R10: Opcode 0x00 with neither column nor row finishes with no delay and no wait.
- R11: Any other request idles for the chip delay after its last byte when `cfg_rb_present`=0. When `cfg_rb_present`=1 it raises `wait_req` with `wait_poll`=0 and `wait_tmo_ms`=400 instead. `wait_req` stays high until `wait_done`, and `done` follows in the next cycle.
- R12: The chip delay is `cfg_chip_dly` clock cycles. A value of 0 selects the default of 20 µs, which is 20·CLK_MHZ cycles (2000 at the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_opcode | input | 8 | Command opcode |
| req_col | input | COL_W | Flat column address |
| req_col_vld | input | 1 | Column present |
| req_row | input | 24 | Row (page) address |
| req_row_vld | input | 1 | Row present |
| cfg_bus16 | input | 1 | 16-bit data bus |
| cfg_row3 | input | 1 | Three row address bytes |
| cfg_rb_present | input | 1 | Ready/busy line is wired |
| cfg_chip_dly | input | DLY_W | Chip delay in cycles, 0 for default |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq | output | DQ_W | Data lines |
| wait_req | output | 1 | Hand-off to the ready waiter |
| wait_poll | output | 1 | 1: poll status, 0: watch ready/busy |
| wait_tmo_ms | output | TMO_W | Wait limit in milliseconds |
| wait_done | input | 1 | Waiter finished |
| done | output | 1 | Request complete pulse |

## Verification
Program setup is swept over columns on both sides of each region boundary (0, 1, 255, 256, 257, 511, 512, 527), with both bus widths and both row lengths. This separates a wrong pointer choice, a missing rebase, and a shift applied before rebasing instead of after. Single cases then cover the rest. A read-ID opcode on the 16-bit bus shows the shift exemption. Reads with and without addresses, and with and without a ready/busy line, separate the three completion paths. Reset is run in both ready/busy settings, and a zero delay setting exposes the default chip delay through the length of the idle gap.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  localparam int ROW_W = 24;

  localparam logic [7:0] OP_PTR_A     = 8'h00;
  localparam logic [7:0] OP_PTR_B     = 8'h01;
  localparam logic [7:0] OP_PTR_SPARE = 8'h50;
  localparam logic [7:0] OP_PROG_SET  = 8'h80;
  localparam logic [7:0] OP_PROG      = 8'h10;
  localparam logic [7:0] OP_ERASE_A   = 8'h60;
  localparam logic [7:0] OP_ERASE_B   = 8'hD0;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_READ_ID   = 8'h90;
  localparam logic [7:0] OP_PARAM     = 8'hEC;
  localparam logic [7:0] OP_GET_FEAT  = 8'hEE;
  localparam logic [7:0] OP_SET_FEAT  = 8'hEF;
  localparam logic [7:0] OP_RESET     = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PTR, ST_CMD, ST_COL, ST_ROW0, ST_ROW1, ST_ROW2,
    ST_DLY, ST_STAT, ST_WAIT, ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    FIN_NOW, FIN_DELAY, FIN_READY, FIN_RESET
  } fin_kind_t;

  // opcodes whose address cycles are always byte wide
  function automatic logic op_is_8bit(input logic [7:0] op);
    return (op == OP_READ_ID) || (op == OP_PARAM) ||
           (op == OP_GET_FEAT) || (op == OP_SET_FEAT);
  endfunction

  // opcodes that complete right after the latch phase
  function automatic logic op_no_wait(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE_A) || (op == OP_ERASE_B) ||
           (op == OP_PROG_SET) || (op == OP_STATUS) ||
           (op == OP_READ_ID) || (op == OP_SET_FEAT);
  endfunction

endpackage

// File: rtl/nseq_col_map.sv
module nseq_col_map
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int COL_W      = 10
) (
  input  logic [7:0]       op,
  input  logic [COL_W-1:0] col,
  input  logic             bus16,
  output logic             ptr_need,
  output logic [7:0]       ptr_op,
  output logic [7:0]       col_byte
);

  localparam logic [COL_W-1:0] PAGE_C = COL_W'(PAGE_BYTES);
  localparam logic [COL_W-1:0] HALF_C = COL_W'(256);

  logic [COL_W-1:0] rebased;
  logic [COL_W-1:0] shifted;
  logic             unused_hi;

  always_comb begin
    ptr_need = (op == OP_PROG_SET);
    ptr_op   = OP_PTR_A;
    rebased  = col;
    if (ptr_need) begin
      if (col >= PAGE_C) begin
        ptr_op  = OP_PTR_SPARE;
        rebased = col - PAGE_C;
      end else if (col >= HALF_C) begin
        ptr_op  = OP_PTR_B;
        rebased = col - HALF_C;
      end
    end
    shifted = (bus16 && !op_is_8bit(op)) ? (rebased >> 1) : rebased;
  end

  assign col_byte  = shifted[7:0];
  assign unused_hi = ^shifted[COL_W-1:8];

endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe #(
  parameter int WE_LOW  = 2,
  parameter int WE_HIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic we_n,
  output logic last
);

  localparam int BYTE_CYC = WE_LOW + WE_HIGH;
  localparam int CNT_W    = $clog2(BYTE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign last = active && (cnt_q == CNT_W'(BYTE_CYC - 1));
  assign we_n = !(active && (cnt_q < CNT_W'(WE_LOW)));

  always_comb begin
    cnt_n = cnt_q;
    if (!active || last) cnt_n = '0;
    else                 cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/nseq_dly_timer.sv
module nseq_dly_timer #(
  parameter int DLY_W       = 16,
  parameter int DEFAULT_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] cfg_dly,
  output logic             expired
);

  localparam logic [DLY_W-1:0] DEF_C = DLY_W'(DEFAULT_CYC);

  logic [DLY_W-1:0] cnt_q, cnt_n, eff;

  assign eff     = (cfg_dly == '0) ? DEF_C : cfg_dly;
  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (load)              cnt_n = eff - 1'b1;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 16,
  parameter int DLY_W      = 16,
  parameter int CLK_MHZ    = 100,
  parameter int WE_LOW     = 2,
  parameter int WE_HIGH    = 2,
  parameter int POLL_MS    = 250,
  parameter int RDY_MS     = 400,
  parameter int TMO_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_col_vld,
  input  logic [23:0]       req_row,
  input  logic              req_row_vld,
  input  logic              cfg_bus16,
  input  logic              cfg_row3,
  input  logic              cfg_rb_present,
  input  logic [DLY_W-1:0]  cfg_chip_dly,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic [DQ_W-1:0]   nand_dq,
  output logic              wait_req,
  output logic              wait_poll,
  output logic [TMO_W-1:0]  wait_tmo_ms,
  input  logic              wait_done,
  output logic              done
);

  localparam int DEF_DLY = 20 * CLK_MHZ;
  localparam int DQ_PAD  = DQ_W - 8;

  seq_state_t           state_q, state_n, tail_st;
  fin_kind_t            fin_q, fin_w;
  logic [7:0]           op_q, ptr_op_q, col_byte_q;
  logic [ROW_W-1:0]     row_q;
  logic                 colv_q, rowv_q, row3_q;
  logic [DLY_W-1:0]     dly_q;
  logic                 cap_en, latch_act, byte_last, dly_load, dly_exp;
  logic                 ptr_need_w;
  logic [7:0]           ptr_op_w, col_byte_w, byte_out;

  nseq_col_map #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_col_map (
    .op       (req_opcode),
    .col      (req_col),
    .bus16    (cfg_bus16),
    .ptr_need (ptr_need_w),
    .ptr_op   (ptr_op_w),
    .col_byte (col_byte_w)
  );

  nseq_strobe #(.WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (latch_act),
    .we_n   (nand_we_n),
    .last   (byte_last)
  );

  nseq_dly_timer #(.DLY_W(DLY_W), .DEFAULT_CYC(DEF_DLY)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (dly_load),
    .cfg_dly (dly_q),
    .expired (dly_exp)
  );

  // completion class decided at acceptance
  always_comb begin
    if (op_no_wait(req_opcode))
      fin_w = FIN_NOW;
    else if (req_opcode == OP_RESET)
      fin_w = cfg_rb_present ? FIN_READY : FIN_RESET;
    else if (req_opcode == OP_PTR_A && !req_col_vld && !req_row_vld)
      fin_w = FIN_NOW;
    else
      fin_w = cfg_rb_present ? FIN_READY : FIN_DELAY;
  end

  always_comb begin
    unique case (fin_q)
      FIN_NOW:   tail_st = ST_DONE;
      FIN_READY: tail_st = ST_WAIT;
      default:   tail_st = ST_DLY;
    endcase
  end

  always_comb begin
    state_n = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        cap_en  = 1'b1;
        state_n = ptr_need_w ? ST_PTR : ST_CMD;
      end
      ST_PTR:  if (byte_last) state_n = ST_CMD;
      ST_CMD:  if (byte_last)
                 state_n = colv_q ? ST_COL : (rowv_q ? ST_ROW0 : tail_st);
      ST_COL:  if (byte_last) state_n = rowv_q ? ST_ROW0 : tail_st;
      ST_ROW0: if (byte_last) state_n = ST_ROW1;
      ST_ROW1: if (byte_last) state_n = row3_q ? ST_ROW2 : tail_st;
      ST_ROW2: if (byte_last) state_n = tail_st;
      ST_DLY:  if (dly_exp)
                 state_n = (fin_q == FIN_RESET) ? ST_STAT : ST_DONE;
      ST_STAT: if (byte_last) state_n = ST_WAIT;
      ST_WAIT: if (wait_done) state_n = ST_DONE;
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  assign dly_load  = (state_n == ST_DLY) && (state_q != ST_DLY);
  assign latch_act = (state_q == ST_PTR)  || (state_q == ST_CMD)  ||
                     (state_q == ST_COL)  || (state_q == ST_ROW0) ||
                     (state_q == ST_ROW1) || (state_q == ST_ROW2) ||
                     (state_q == ST_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= '0;
      ptr_op_q   <= '0;
      col_byte_q <= '0;
      row_q      <= '0;
      colv_q     <= 1'b0;
      rowv_q     <= 1'b0;
      row3_q     <= 1'b0;
      dly_q      <= '0;
      fin_q      <= FIN_NOW;
    end else if (cap_en) begin
      op_q       <= req_opcode;
      ptr_op_q   <= ptr_op_w;
      col_byte_q <= col_byte_w;
      row_q      <= req_row;
      colv_q     <= req_col_vld;
      rowv_q     <= req_row_vld;
      row3_q     <= cfg_row3;
      dly_q      <= cfg_chip_dly;
      fin_q      <= fin_w;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PTR:  byte_out = ptr_op_q;
      ST_CMD:  byte_out = op_q;
      ST_COL:  byte_out = col_byte_q;
      ST_ROW0: byte_out = row_q[7:0];
      ST_ROW1: byte_out = row_q[15:8];
      ST_ROW2: byte_out = row_q[23:16];
      ST_STAT: byte_out = OP_STATUS;
      default: byte_out = 8'h00;
    endcase
  end

  assign nand_dq     = {{DQ_PAD{1'b0}}, byte_out};
  assign nand_ce_n   = !latch_act;
  assign nand_cle    = (state_q == ST_PTR) || (state_q == ST_CMD) ||
                       (state_q == ST_STAT);
  assign nand_ale    = (state_q == ST_COL)  || (state_q == ST_ROW0) ||
                       (state_q == ST_ROW1) || (state_q == ST_ROW2);
  assign req_ready   = (state_q == ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign wait_req    = (state_q == ST_WAIT);
  assign wait_poll   = (fin_q == FIN_RESET);
  assign wait_tmo_ms = wait_poll ? TMO_W'(POLL_MS) : TMO_W'(RDY_MS);

endmodule

// File: rtl/nseq_checker.sv
module nseq_checker #(
  parameter int DQ_W    = 16,
  parameter int TMO_W   = 10,
  parameter int POLL_MS = 250,
  parameter int RDY_MS  = 400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             nand_ce_n,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic             nand_we_n,
  input logic [DQ_W-1:0]  nand_dq,
  input logic             wait_req,
  input logic             wait_poll,
  input logic [TMO_W-1:0] wait_tmo_ms,
  input logic             wait_done,
  input logic             done
);

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R2
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n); // R2
  AST_LATCH_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |=> (nand_we_n || $stable(nand_dq))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && !wait_req && !done)); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !wait_done) |=> wait_req); // R11
  AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && wait_poll) |-> (wait_tmo_ms == TMO_W'(POLL_MS))); // R9
  AST_READY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !wait_poll) |-> (wait_tmo_ms == TMO_W'(RDY_MS))); // R11

endmodule

bind nand_cmd_seq nseq_checker #(
  .DQ_W(DQ_W), .TMO_W(TMO_W), .POLL_MS(POLL_MS), .RDY_MS(RDY_MS)
) u_nseq_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_dq(nand_dq), .wait_req(wait_req),
  .wait_poll(wait_poll), .wait_tmo_ms(wait_tmo_ms), .wait_done(wait_done),
  .done(done)
);

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;

  localparam int COL_W = 10, DQ_W = 16, DLY_W = 16, TMO_W = 10;
  localparam int WE_LOW = 2, CLK_MHZ = 100, PAGE = 512;

  logic clk, rst_n;
  logic req_valid, req_ready, req_col_vld, req_row_vld;
  logic [7:0] req_opcode;
  logic [COL_W-1:0] req_col;
  logic [23:0] req_row;
  logic cfg_bus16, cfg_row3, cfg_rb_present;
  logic [DLY_W-1:0] cfg_chip_dly;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n;
  logic [DQ_W-1:0] nand_dq;
  logic wait_req, wait_poll, wait_done, done;
  logic [TMO_W-1:0] wait_tmo_ms;

  int chk_cnt = 0, pass_cnt = 0;
  logic [8:0] exp_b[16];
  logic [8:0] obs_b[16];
  int exp_n, exp_gap, exp_kind;

  nand_cmd_seq i_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_col(req_col), .req_col_vld(req_col_vld),
    .req_row(req_row), .req_row_vld(req_row_vld), .cfg_bus16(cfg_bus16),
    .cfg_row3(cfg_row3), .cfg_rb_present(cfg_rb_present),
    .cfg_chip_dly(cfg_chip_dly), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_dq(nand_dq),
    .wait_req(wait_req), .wait_poll(wait_poll), .wait_tmo_ms(wait_tmo_ms),
    .wait_done(wait_done), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    chk_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic push(input bit is_cmd, input logic [7:0] b);
    exp_b[exp_n] = {is_cmd, b};
    exp_n++;
  endtask

  task automatic build_exp(input logic [7:0] op, input int col, input bit colv,
                           input logic [23:0] row, input bit rowv,
                           input bit b16, input bit r3, input bit rb,
                           input int dly);
    int c, eff;
    c = col; exp_n = 0; exp_gap = 0; exp_kind = 0;
    eff = (dly == 0) ? 20 * CLK_MHZ : dly;
    if (op == 8'h80) begin
      if (col >= PAGE)     begin push(1, 8'h50); c = col - PAGE; end
      else if (col < 256)  push(1, 8'h00);
      else                 begin push(1, 8'h01); c = col - 256; end
    end
    push(1, op);
    if (colv) begin
      if (b16 && !(op == 8'h90 || op == 8'hEC || op == 8'hEE || op == 8'hEF))
        c = c / 2;
      push(0, c[7:0]);
    end
    if (rowv) begin
      push(0, row[7:0]); push(0, row[15:8]);
      if (r3) push(0, row[23:16]);
    end
    if (op == 8'h10 || op == 8'h60 || op == 8'hD0 || op == 8'h80 ||
        op == 8'h70 || op == 8'h90 || op == 8'hEF) exp_kind = 0;
    else if (op == 8'hFF) begin
      if (rb) exp_kind = 1;
      else begin push(1, 8'h70); exp_gap = eff; exp_kind = 2; end
    end else if (op == 8'h00 && !colv && !rowv) exp_kind = 0;
    else if (rb) exp_kind = 1;
    else exp_gap = eff;
  endtask

  task automatic run_req(input string tag, input logic [7:0] op, input int col,
                         input bit colv, input logic [23:0] row, input bit rowv,
                         input bit b16, input bit r3, input bit rb, input int dly);
    int n_obs, gap, low, wcyc, kind, tmo, guard;
    bit prev_we, fin;
    build_exp(op, col, colv, row, rowv, b16, r3, rb, dly);
    @(negedge clk);
    req_opcode = op; req_col = COL_W'(col); req_col_vld = colv;
    req_row = row; req_row_vld = rowv; cfg_bus16 = b16; cfg_row3 = r3;
    cfg_rb_present = rb; cfg_chip_dly = DLY_W'(dly); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1", "ready while busy", int'(req_ready), 0);
    n_obs = 0; gap = 0; low = 0; wcyc = 0; kind = 0; tmo = 0; guard = 0;
    prev_we = 1'b1; fin = 1'b0;
    while (!fin && guard < 10000) begin
      if (!nand_we_n && prev_we) begin
        if (n_obs < 16) obs_b[n_obs] = {nand_cle, nand_dq[7:0]};
        n_obs++;
        check((nand_ale == !nand_cle) && !nand_ce_n && nand_dq[15:8] == 8'h00,
              "R2", "latch lines", {nand_ce_n, nand_cle, nand_ale}, 0);
      end
      if (!nand_we_n) low++;
      else if (!prev_we) begin
        check(low == WE_LOW, "R2", "strobe low width", low, WE_LOW);
        low = 0;
      end
      prev_we = nand_we_n;
      if (!req_ready && nand_ce_n && !wait_req && !done) gap++;
      if (wait_req) begin
        kind = wait_poll ? 2 : 1; tmo = int'(wait_tmo_ms); wcyc++;
        if (wcyc == 3) wait_done = 1'b1;
      end else wait_done = 1'b0;
      if (done) fin = 1'b1;
      guard++;
      @(negedge clk);
    end
    wait_done = 1'b0;
    check(fin, tag, "request finished", int'(fin), 1);
    check(!done && req_ready, "R1", "done pulse then idle",
          {done, req_ready}, 1);
    check(n_obs == exp_n, tag, "latch byte count", n_obs, exp_n);
    for (int i = 0; i < exp_n && i < n_obs && i < 16; i++)
      check(obs_b[i] == exp_b[i], tag, $sformatf("latch byte %0d", i),
            obs_b[i], exp_b[i]);
    check(gap == exp_gap, tag, "idle gap cycles", gap, exp_gap);
    check(kind == exp_kind, tag, "wait hand-off kind", kind, exp_kind);
    if (exp_kind != 0)
      check(tmo == ((exp_kind == 2) ? 250 : 400), tag, "wait limit", tmo,
            (exp_kind == 2) ? 250 : 400);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
    $finish;
  end

  initial begin
    int cols[8] = '{0, 1, 255, 256, 257, 511, 512, 527};
    rst_n = 1'b0; req_valid = 1'b0; wait_done = 1'b0;
    req_opcode = '0; req_col = '0; req_col_vld = 1'b0; req_row = '0;
    req_row_vld = 1'b0; cfg_bus16 = 1'b0; cfg_row3 = 1'b0;
    cfg_rb_present = 1'b0; cfg_chip_dly = '0;
    repeat (3) @(negedge clk);
    check(req_ready && nand_ce_n && nand_we_n && !nand_cle && !nand_ale &&
          !done && !wait_req, "R1", "reset state", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && nand_ce_n, "R1", "idle after reset", int'(req_ready), 1);

    // program setup sweep over region boundaries: R3 R4 R5 R6 R8
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 2; r++)
        for (int k = 0; k < 8; k++)
          run_req("R3/R4", 8'h80, cols[k], 1'b1, 24'hA5C31E, 1'b1,
                  b[0], r[0], 1'b0, 5);

    run_req("R5", 8'h90, 8'h40, 1'b1, 24'h0, 1'b0, 1'b1, 1'b0, 1'b0, 5);
    run_req("R5", 8'h00, 10'h123, 1'b1, 24'h0, 1'b0, 1'b1, 1'b0, 1'b0, 5);
    run_req("R3", 8'h50, 600, 1'b1, 24'h123456, 1'b1, 1'b0, 1'b1, 1'b0, 4);
    run_req("R11", 8'h00, 10'h0AB, 1'b1, 24'h01F2E3, 1'b1, 1'b0, 1'b0, 1'b0, 7);
    run_req("R11", 8'h00, 10'h0AB, 1'b1, 24'h01F2E3, 1'b1, 1'b0, 1'b1, 1'b1, 7);
    run_req("R10", 8'h00, 0, 1'b0, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0, 7);
    run_req("R7/R8", 8'h60, 0, 1'b0, 24'hBEEF42, 1'b1, 1'b0, 1'b1, 1'b0, 7);
    run_req("R7/R8", 8'h10, 0, 1'b0, 24'h0, 1'b0, 1'b0, 1'b0, 1'b1, 7);
    run_req("R6", 8'h90, 8'h00, 1'b1, 24'h0, 1'b0, 1'b0, 1'b0, 1'b1, 7);
    run_req("R9", 8'hFF, 0, 1'b0, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0, 6);
    run_req("R9", 8'hFF, 0, 1'b0, 24'h0, 1'b0, 1'b0, 1'b0, 1'b1, 6);
    run_req("R12", 8'h00, 10'h010, 1'b1, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0);

    $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
    $finish;
  end

endmodule